// File: doc/BRIEF.md
# Multi-mode ADC channel sequencer

This block is the digital control core of a serial multichannel converter. A host sends 16-bit command words over a four-wire serial port made of an active-low select, a serial clock, a data input and a data output. Each word either keeps the current settings or selects one of three ways of choosing the next channel. In the direct mode the host names the channel. In the mask mode the block steps through the channels enabled in a 16-bit mask. In the span mode the block counts from channel 0 up to a programmed top channel. The block drives the analog multiplexer select and issues a sample request at the start of every frame. It shifts each result out two frames after the frame that chose its channel.

The serial pins are assumed to be already synchronised to `clk` and to toggle far slower than it. Edges of the serial clock are found by comparing each pin with its value one `clk` cycle earlier. The converter lies outside the block. It presents a 12-bit value on `conv_data` for whatever channel `mux_ch` names, and the block captures that value in the cycle where `conv_start` pulses.

Top module: `adcseq_core`

## Requirements
- R1: A frame starts when `sel_n` falls. `mosi` is taken MSB first on each rising `sck` edge. Bit 15 of the output word is on `miso` from the start of the frame, and each falling `sck` edge moves the next bit onto `miso`. A frame that receives 16 rising edges commits its command, and further edges in the same frame are ignored.
- R2: Command bits 15:12 hold the opcode. Opcode 0000, and any opcode that is not defined here, changes no setting, and its bits 11:0 are ignored. On such a frame the channel still moves on as the current mode dictates: the direct mode keeps its channel, and the mask and span modes step once.
- R3: Opcodes 0001, 0010 and 0011 update the range bit (bit 6), the power-down bit (bit 5) and the format bit (bit 4) only when bit 11 is 1. When bit 11 is 0, the earlier values of these bits are kept.
- R4: Opcode 0001 enters the direct mode, and bits 10:7 name the channel. `mux_ch` shows that channel after frame n ends. The channel is sampled when frame n+1 starts, and its result is shifted out in frame n+2.
- R5: Opcode 1000 arms mask loading. All 16 bits of the following frame are then stored as the channel mask, where bit i set enables channel i. That following frame is not decoded as a command.
- R6: Opcode 0010 enters the mask mode. It selects the lowest enabled channel when it arrives from another mode or when bit 10 is 1. Otherwise it selects the next enabled channel above the current one, wrapping to the bottom. An empty mask selects channel 0.
- R7: Opcode 1001 stores bits 9:6 as the top channel of the span mode. Opcode 0011 enters the span mode at channel 0 when it arrives from another mode or when bit 10 is 1. Each later step goes to the current channel plus one, or goes to 0 when the current channel is at or above the top.
- R8: `range_x2` follows the committed range bit from the end of the frame that wrote it.
- R9: At the 16th falling `sck` edge of every frame, `pwr_down` takes the power-down bit that was in effect when that frame started. A 1 written in frame n therefore raises `pwr_down` during frame n+1, and a 0 clears it the same way.
- R10: The output word holds the 12-bit result in bits 11:0. With the format bit at 0, bits 15:12 hold the channel address of the result. With the format bit at 1, bits 15:12 hold `gpio_in[3:0]` as captured when the frame starts. A format bit written in frame n applies to the word of frame n+1.
- R11: A frame that ends with fewer than 16 rising `sck` edges changes no setting, no channel and no stored result.
- R12: After reset the block is in the direct mode on channel 0, with every setting bit at 0, all channels enabled in the mask and a top channel of 15. The word of the first frame after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial command data from the host |
| miso | output | 1 | Serial result data to the host |
| gpio_in | input | 4 | Pin levels reported in the alternative word format |
| conv_data | input | 12 | Converter result for the channel on `mux_ch` |
| conv_start | output | 1 | One-cycle sample request at the start of each frame |
| mux_ch | output | 4 | Multiplexer channel select |
| range_x2 | output | 1 | Double input span selected |
| pwr_down | output | 1 | Power-down request to the analog part |

## Verification
A wrong channel register shows on `mux_ch` as soon as the frame that commits it ends. It shows a second time two frames later, as a wrong address and value in the shifted word. A wrong mask, top channel or mode does not show when it is written. It shows on the next stepping frame, when `mux_ch` leaves the expected sequence. A stored result or format bit that a short frame disturbs shows in the word of the next complete frame. A power-down bit latched at the wrong time shows at the end of the frame that follows the write.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int NCH     = 16;
  localparam int CHW     = $clog2(NCH);
  localparam int DW      = 12;
  localparam int FW      = 16;
  localparam int GPIO_W  = FW - DW;

  // command field positions
  localparam int OP_HI   = 15;
  localparam int OP_LO   = 12;
  localparam int B_WREN  = 11;
  localparam int B_RESTART = 10;
  localparam int CH_HI   = 10;
  localparam int CH_LO   = 7;
  localparam int TOP_HI  = 9;
  localparam int TOP_LO  = 6;
  localparam int B_RANGE = 6;
  localparam int B_PD    = 5;
  localparam int B_FMT   = 4;

  localparam logic [3:0] OP_KEEP      = 4'b0000;
  localparam logic [3:0] OP_DIRECT    = 4'b0001;
  localparam logic [3:0] OP_MASKSEQ   = 4'b0010;
  localparam logic [3:0] OP_SPANSEQ   = 4'b0011;
  localparam logic [3:0] OP_ARM_MASK  = 4'b1000;
  localparam logic [3:0] OP_SET_TOP   = 4'b1001;

  typedef enum logic [1:0] {
    MD_DIRECT  = 2'd0,
    MD_MASKSEQ = 2'd1,
    MD_SPANSEQ = 2'd2
  } seq_mode_e;

  function automatic logic [CHW-1:0] lowest_set(input logic [NCH-1:0] m);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) r = CHW'(i);
    return r;
  endfunction

  function automatic logic [CHW-1:0] next_set(input logic [NCH-1:0] m,
                                              input logic [CHW-1:0] cur);
    logic [CHW-1:0] r;
    logic           hit;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      if (!hit && m[(int'(cur) + k) % NCH]) begin
        r   = CHW'((int'(cur) + k) % NCH);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [CHW-1:0] next_span(input logic [CHW-1:0] cur,
                                               input logic [CHW-1:0] top);
    return (cur >= top) ? '0 : cur + CHW'(1);
  endfunction

  function automatic logic [FW-1:0] pack_word(input logic              valid,
                                              input logic              use_gpio,
                                              input logic [GPIO_W-1:0] gpio,
                                              input logic [CHW-1:0]    ch,
                                              input logic [DW-1:0]     data);
    logic [GPIO_W-1:0] head;
    head = use_gpio ? gpio : GPIO_W'(ch);
    return valid ? {head, data} : '0;
  endfunction

endpackage

// File: rtl/adcseq_serial.sv
module adcseq_serial
  import adcseq_pkg::*;
#(
  parameter int WORD_W = FW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic [WORD_W-1:0] load_word,
  output logic              miso,
  output logic              frame_start,
  output logic              frame_done,
  output logic              pd_edge,
  output logic [WORD_W-1:0] cmd_word
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SPENT     = CNT_W'(WORD_W + 1);

  logic              sel_q, sck_q;
  logic              in_frame, sck_rise, sck_fall;
  logic [CNT_W-1:0]  nbit_q;
  logic [WORD_W-2:0] rx_q;
  logic [WORD_W-1:0] tx_q;

  assign frame_start = sel_q & ~sel_n;
  assign in_frame    = ~sel_n & ~sel_q;
  assign sck_rise    = in_frame & sck & ~sck_q;
  assign sck_fall    = in_frame & ~sck & sck_q;
  assign frame_done  = sck_rise && (nbit_q == LAST_RISE);
  assign pd_edge     = sck_fall && (nbit_q == FULL);
  assign cmd_word    = {rx_q, mosi};
  assign miso        = tx_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sck_q  <= 1'b0;
      nbit_q <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      sel_q <= sel_n;
      sck_q <= sck;
      if (frame_start) begin
        nbit_q <= '0;
        tx_q   <= load_word;
      end else begin
        if (sck_rise && nbit_q < FULL) begin
          rx_q   <= {rx_q[WORD_W-3:0], mosi};
          nbit_q <= nbit_q + CNT_W'(1);
        end
        if (sck_fall && nbit_q != '0 && nbit_q <= FULL) begin
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
          if (nbit_q == FULL) nbit_q <= SPENT;
        end
      end
    end
  end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = NCH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      frame_done,
  input  logic                      pd_edge,
  input  logic [FW-1:0]             cmd_word,
  output logic [$clog2(NUM_CH)-1:0] mux_ch,
  output logic                      range_x2,
  output logic                      fmt_gpio,
  output logic                      pwr_down,
  output seq_mode_e                 mode_q,
  output logic                      armed_q,
  output logic [NUM_CH-1:0]         mask_q
);

  localparam int SW = $clog2(NUM_CH);

  logic [SW-1:0] ch_q, top_q, ch_d, top_d, step_ch;
  logic [NUM_CH-1:0] mask_d;
  seq_mode_e     mode_d;
  logic          arm_d, wr_set;
  logic          rng_q, pd_q, fmt_q, pd_frame_q, pwr_q;
  logic [3:0]    op;
  logic          fresh;

  assign op = cmd_word[OP_HI:OP_LO];

  always_comb begin
    unique case (mode_q)
      MD_MASKSEQ: step_ch = next_set(mask_q, ch_q);
      MD_SPANSEQ: step_ch = next_span(ch_q, top_q);
      default:    step_ch = ch_q;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    ch_d   = step_ch;
    mask_d = mask_q;
    top_d  = top_q;
    arm_d  = 1'b0;
    wr_set = 1'b0;
    fresh  = cmd_word[B_RESTART];
    if (armed_q) begin
      mask_d = cmd_word[NUM_CH-1:0];
    end else begin
      unique case (op)
        OP_DIRECT: begin
          mode_d = MD_DIRECT;
          ch_d   = cmd_word[CH_HI:CH_LO];
          wr_set = cmd_word[B_WREN];
        end
        OP_MASKSEQ: begin
          fresh  = cmd_word[B_RESTART] || (mode_q != MD_MASKSEQ);
          mode_d = MD_MASKSEQ;
          ch_d   = fresh ? lowest_set(mask_q) : next_set(mask_q, ch_q);
          wr_set = cmd_word[B_WREN];
        end
        OP_SPANSEQ: begin
          fresh  = cmd_word[B_RESTART] || (mode_q != MD_SPANSEQ);
          mode_d = MD_SPANSEQ;
          ch_d   = fresh ? '0 : next_span(ch_q, top_q);
          wr_set = cmd_word[B_WREN];
        end
        OP_ARM_MASK: arm_d = 1'b1;
        OP_SET_TOP:  top_d = cmd_word[TOP_HI:TOP_LO];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_DIRECT;
      ch_q    <= '0;
      mask_q  <= '1;
      top_q   <= SW'(NUM_CH - 1);
      armed_q <= 1'b0;
      rng_q   <= 1'b0;
      pd_q    <= 1'b0;
      fmt_q   <= 1'b0;
    end else if (frame_done) begin
      mode_q  <= mode_d;
      ch_q    <= ch_d;
      mask_q  <= mask_d;
      top_q   <= top_d;
      armed_q <= arm_d;
      if (wr_set) begin
        rng_q <= cmd_word[B_RANGE];
        pd_q  <= cmd_word[B_PD];
        fmt_q <= cmd_word[B_FMT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_frame_q <= 1'b0;
      pwr_q      <= 1'b0;
    end else begin
      if (frame_start) pd_frame_q <= pd_q;
      if (pd_edge)     pwr_q      <= pd_frame_q;
    end
  end

  assign mux_ch   = ch_q;
  assign range_x2 = rng_q;
  assign fmt_gpio = fmt_q;
  assign pwr_down = pwr_q;

endmodule

// File: rtl/adcseq_pipe.sv
module adcseq_pipe
  import adcseq_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic [CHW-1:0]    mux_ch,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              fmt_gpio,
  output logic [FW-1:0]     out_word,
  output logic              res_valid
);

  logic [CHW-1:0]    stg_ch_q, res_ch_q;
  logic [DATA_W-1:0] stg_data_q, res_data_q;

  // stage 1: sample taken as the frame opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ch_q   <= '0;
      stg_data_q <= '0;
    end else if (frame_start) begin
      stg_ch_q   <= mux_ch;
      stg_data_q <= conv_data;
    end
  end

  // stage 2: result kept for the next frame, only on a complete frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ch_q   <= '0;
      res_data_q <= '0;
      res_valid  <= 1'b0;
    end else if (frame_done) begin
      res_ch_q   <= stg_ch_q;
      res_data_q <= stg_data_q;
      res_valid  <= 1'b1;
    end
  end

  assign out_word = pack_word(res_valid, fmt_gpio, gpio_in, res_ch_q, res_data_q);

endmodule

// File: rtl/adcseq_core.sv
module adcseq_core
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic [DW-1:0]     conv_data,
  output logic              conv_start,
  output logic [CHW-1:0]    mux_ch,
  output logic              range_x2,
  output logic              pwr_down
);

  logic            frame_start, frame_done, pd_edge;
  logic [FW-1:0]   cmd_word, out_word;
  logic            fmt_gpio, armed_q, res_valid;
  logic [NCH-1:0]  mask_q;
  seq_mode_e       mode_q;

  adcseq_serial #(.WORD_W(FW)) serial_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .sck        (sck),
    .mosi       (mosi),
    .load_word  (out_word),
    .miso       (miso),
    .frame_start(frame_start),
    .frame_done (frame_done),
    .pd_edge    (pd_edge),
    .cmd_word   (cmd_word)
  );

  adcseq_ctrl #(.NUM_CH(NCH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .frame_done (frame_done),
    .pd_edge    (pd_edge),
    .cmd_word   (cmd_word),
    .mux_ch     (mux_ch),
    .range_x2   (range_x2),
    .fmt_gpio   (fmt_gpio),
    .pwr_down   (pwr_down),
    .mode_q     (mode_q),
    .armed_q    (armed_q),
    .mask_q     (mask_q)
  );

  adcseq_pipe #(.DATA_W(DW)) pipe_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .frame_done (frame_done),
    .mux_ch     (mux_ch),
    .conv_data  (conv_data),
    .gpio_in    (gpio_in),
    .fmt_gpio   (fmt_gpio),
    .out_word   (out_word),
    .res_valid  (res_valid)
  );

  assign conv_start = frame_start;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
  import adcseq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           sel_n,
  input logic           sck,
  input logic           miso,
  input logic           frame_start,
  input logic           frame_done,
  input logic           pd_edge,
  input logic [FW-1:0]  cmd_word,
  input logic [CHW-1:0] mux_ch,
  input logic           range_x2,
  input logic           pwr_down,
  input seq_mode_e      mode_q,
  input logic           armed_q,
  input logic [NCH-1:0] mask_q,
  input logic           res_valid
);

  logic plain_step;
  assign plain_step = frame_done && !armed_q && (cmd_word[OP_HI:OP_LO] == OP_KEEP);

  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(mux_ch));

  // R8
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(range_x2));

  // R9
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_edge |=> $stable(pwr_down));

  // R9
  pd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_edge |-> (!sel_n && $fell(sck)));

  // R1
  start_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $fell(sel_n));

  // R1
  done_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!sel_n && $rose(sck)));

  // R1
  events_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, frame_done, pd_edge}));

  // R6
  mask_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && mode_q == MD_MASKSEQ && mask_q != '0) |=> mask_q[mux_ch]);

  // R7
  span_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_step && mode_q == MD_SPANSEQ) |=>
      (mux_ch == '0 || mux_ch == $past(mux_ch) + CHW'(1)));

  // R12
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !res_valid) |=> (miso == 1'b0));

endmodule

bind adcseq_core adcseq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n      (sel_n),
  .sck        (sck),
  .miso       (miso),
  .frame_start(frame_start),
  .frame_done (frame_done),
  .pd_edge    (pd_edge),
  .cmd_word   (cmd_word),
  .mux_ch     (mux_ch),
  .range_x2   (range_x2),
  .pwr_down   (pwr_down),
  .mode_q     (mode_q),
  .armed_q    (armed_q),
  .mask_q     (mask_q),
  .res_valid  (res_valid)
);

// File: tb/adcseq_core_tb_top.sv
module adcseq_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic [3:0]  gpio_in = 4'h0;
  logic [11:0] conv_data;
  logic        conv_start;
  logic [3:0]  mux_ch;
  logic        range_x2;
  logic        pwr_down;

  logic [11:0] chan_val [16];

  always #4 clk = ~clk;

  // converter stand-in: value depends on the channel and the span setting
  assign conv_data = chan_val[mux_ch] ^ (range_x2 ? 12'hA5A : 12'h000);

  adcseq_core dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .mosi(mosi),
    .miso(miso), .gpio_in(gpio_in), .conv_data(conv_data),
    .conv_start(conv_start), .mux_ch(mux_ch), .range_x2(range_x2),
    .pwr_down(pwr_down)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  finished = 1'b0;

  // bench model state
  int          m_mode;   // 0 direct, 1 mask walk, 2 span walk
  logic [3:0]  m_ch, m_top, m_res_ch;
  logic [15:0] m_mask;
  logic        m_rng, m_pd, m_fmt, m_arm, m_pwr, m_res_ok;
  logic [11:0] m_res_data;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] b_lowest(input logic [15:0] m);
    int i = 0;
    while (i < 16 && !m[i]) i++;
    return (i == 16) ? 4'd0 : 4'(i);
  endfunction

  function automatic logic [3:0] b_after(input logic [15:0] m, input logic [3:0] c);
    logic [31:0] dbl = {m, m};
    int j = int'(c) + 1;
    while (j <= int'(c) + 16 && !dbl[j]) j++;
    return (m == 16'h0) ? 4'd0 : 4'(j % 16);
  endfunction

  function automatic logic [3:0] b_span(input logic [3:0] c, input logic [3:0] t);
    if (c < t) return c + 4'd1;
    return 4'd0;
  endfunction

  function automatic logic [15:0] mk(input logic [3:0] op, input logic wr,
                                     input logic [3:0] f, input logic [6:0] lo);
    return {op, wr, f, lo};
  endfunction

  function automatic logic [15:0] mk_top(input logic [3:0] t);
    return {4'h9, 2'b00, t, 6'b000000};
  endfunction

  task automatic model_step();
    if (m_mode == 1) m_ch = b_after(m_mask, m_ch);
    else if (m_mode == 2) m_ch = b_span(m_ch, m_top);
  endtask

  task automatic model_apply(input logic [15:0] c);
    if (m_arm) begin
      m_arm = 1'b0;
      model_step();
      m_mask = c;
      return;
    end
    case (c[15:12])
      4'h1: begin m_mode = 0; m_ch = c[10:7]; end
      4'h2: begin
        m_ch = (m_mode != 1 || c[10]) ? b_lowest(m_mask) : b_after(m_mask, m_ch);
        m_mode = 1;
      end
      4'h3: begin
        m_ch = (m_mode != 2 || c[10]) ? 4'd0 : b_span(m_ch, m_top);
        m_mode = 2;
      end
      4'h8: begin model_step(); m_arm = 1'b1; end
      4'h9: begin model_step(); m_top = c[9:6]; end
      default: model_step();
    endcase
    if (c[15:12] inside {4'h1, 4'h2, 4'h3} && c[11]) begin
      m_rng = c[6]; m_pd = c[5]; m_fmt = c[4];
    end
  endtask

  task automatic spi_xfer(input logic [15:0] cmd, input int nbits,
                          output logic [15:0] got);
    got = '0;
    @(negedge clk) sel_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = cmd[15-i];
      got[15-i] = miso;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] cmd, input int nbits, input string tag);
    logic [15:0] exp_word, got;
    logic [3:0]  stg_ch, ch_before;
    logic [11:0] stg_data;
    logic        pd_start, rng_before;
    for (int k = 0; k < 16; k++) chan_val[k] = 12'($urandom);
    gpio_in = 4'($urandom);
    @(negedge clk);
    exp_word = m_res_ok ? {(m_fmt ? gpio_in : m_res_ch), m_res_data} : 16'h0;
    stg_ch   = m_ch;
    stg_data = chan_val[m_ch] ^ (m_rng ? 12'hA5A : 12'h000);
    pd_start = m_pd;
    ch_before = mux_ch;
    rng_before = range_x2;
    spi_xfer(cmd, nbits, got);
    if (nbits >= 16) begin
      // R4 R10 word carries the result chosen two frames back
      chk(got == exp_word, {tag, " R4 R10 word"}, got, exp_word);
      m_res_ok = 1'b1; m_res_ch = stg_ch; m_res_data = stg_data;
      m_pwr = pd_start;
      model_apply(cmd);
      chk(mux_ch == m_ch, {tag, " mux"}, 16'(mux_ch), 16'(m_ch));
      chk(range_x2 == m_rng, "R8 R3 range", 16'(range_x2), 16'(m_rng));
      chk(pwr_down == m_pwr, "R9 pwr_down", 16'(pwr_down), 16'(m_pwr));
    end else begin
      // R11 a short frame leaves channel and settings alone
      chk(mux_ch == ch_before, "R11 mux", 16'(mux_ch), 16'(ch_before));
      chk(range_x2 == rng_before, "R11 range", 16'(range_x2), 16'(rng_before));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1D));
    for (int k = 0; k < 16; k++) chan_val[k] = 12'h0;
    m_mode = 0; m_ch = 4'd0; m_top = 4'd15; m_mask = 16'hFFFF;
    m_rng = 0; m_pd = 0; m_fmt = 0; m_arm = 0; m_pwr = 0; m_res_ok = 0;
    m_res_ch = 4'd0; m_res_data = 12'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk(mux_ch == 4'd0, "R12 mux", 16'(mux_ch), 16'h0);
    chk(range_x2 == 1'b0, "R12 range", 16'(range_x2), 16'h0);
    chk(pwr_down == 1'b0, "R12 pwr_down", 16'(pwr_down), 16'h0);
    chk(conv_start == 1'b0, "R12 conv_start", 16'(conv_start), 16'h0);

    frame(mk(4'h1, 1'b0, 4'd3, 7'h00), 16, "R12 first word zero");
    frame(mk(4'h1, 1'b1, 4'd7, 7'b1000000), 16, "R4 direct");
    frame(mk(4'h0, 1'b1, 4'hF, 7'h7F), 16, "R2 keep");
    frame(mk(4'h8, 1'b0, 4'd0, 7'h00), 16, "R5 arm");
    frame(16'h0224, 16, "R5 mask");
    frame(mk(4'h2, 1'b0, 4'd0, 7'h00), 16, "R6 enter");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R6 step");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R6 step");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R6 wrap");
    frame(mk(4'h2, 1'b0, 4'd8, 7'h00), 16, "R6 restart");
    frame(mk_top(4'd2), 16, "R7 top");
    frame(mk(4'h3, 1'b1, 4'd0, 7'b0010000), 16, "R7 enter R10");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R7 step R10");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R7 step");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R7 wrap");
    frame(mk(4'h1, 1'b1, 4'd12, 7'b1100000), 5, "R11 short");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R11 after");
    frame(mk(4'h1, 1'b1, 4'd4, 7'b0100000), 16, "R9 set");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R9 takes effect");
    frame(mk(4'h1, 1'b1, 4'd4, 7'b0000000), 16, "R9 clear");
    frame(mk(4'h1, 1'b0, 4'd9, 7'b1110000), 16, "R3 no write");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R9 released");
    frame(mk(4'h8, 1'b0, 4'd0, 7'h00), 16, "R5 arm");
    frame(16'h0000, 16, "R5 empty mask");
    frame(mk(4'h2, 1'b0, 4'd0, 7'h00), 16, "R6 empty");
    frame(mk(4'h0, 1'b0, 4'd0, 7'h00), 16, "R6 empty step");
    frame(mk(4'h8, 1'b0, 4'd0, 7'h00), 16, "R5 arm");
    frame(16'h8001, 16, "R5 mask ends");
    frame(mk(4'hB, 1'b1, 4'd5, 7'h7F), 16, "R2 undefined");

    for (int n = 0; n < 300; n++) begin
      logic [3:0]  op;
      logic [11:0] lo;
      int          sel, len;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0:       op = 4'h0;
        1, 2:    op = 4'h1;
        3, 4:    op = 4'h2;
        5, 6:    op = 4'h3;
        7:       op = 4'h8;
        8:       op = 4'h9;
        default: op = 4'hB;
      endcase
      lo  = 12'($urandom);
      len = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 15)) : 16;
      frame({op, lo}, len, "R2 R4 R6 R7 random");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule